// File: doc/BRIEF.md
# Prescaled Reloadable Down-Counter Timer

A 32-bit down-counter behind a small synchronous register port. Software writes a reload value, picks a tick rate through a prescale exponent, and enables the timer. The count drops by one on each prescaled tick. When it runs out, a raw status bit is set and, if enabled, a level interrupt is raised. The count then either reloads for periodic operation or parks at zero for one-shot use.

There are three ways to restart the count. Writing the load value restarts it only while the timer is enabled. Writing the count register replaces the count directly. Turning the enable bit from 0 to 1 restarts from the stored load value. Reads are combinational from the current address. Writes take effect at the clock edge on which `req_i` and `we_i` are both high.

Top module: `prescaled_timer`

## Requirements
- R1: After reset, load, count, control and status all read 0 and `irq_o` is low.
- R2: Registers sit at byte offsets 0x00 load, 0x04 count, 0x08 control, 0x0C status. Only word-aligned addresses in that range decode. Any other address reads 0 and ignores writes.
- R3: The control layout is bit0 enable, bit1 auto-reload, bit2 interrupt enable, bits 15:8 prescale exponent. All other control bits read 0.
- R4: A tick lasts 16^p clock cycles, where p is the prescale exponent clamped to MAX_EXP. The first tick lands 16^p cycles after a restart, and j ticks after a restart to N the count reads N-j.
- R5: A load write always stores the reload value. It restarts the count from that value only when enable is set. While disabled, the count is left untouched.
- R6: A count write sets the count to the written value at once, whether or not the timer is enabled. The count only decrements while enabled.
- R7: A control write that takes enable from 0 to 1 restarts from the stored load value. Clearing enable freezes both the count and the prescaler.
- R8: A tick that finds the count at 1 (or at 0 after a restart) is the zero event. It sets status bit0. It raises `irq_o` only when interrupt enable is set.
- R9: On the zero event with auto-reload set, the count takes the load value on the same edge. Without auto-reload, the count holds at 0 and no further zero event occurs until a restart.
- R10: Any write to the status register clears status bit0 and `irq_o`. A zero event on the same edge takes priority.
- R11: No zero event and no status change happen while enable is clear.
- R12: `irq_o` is a level that stays high until the status register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access strobe |
| we_i | input | 1 | Write when high, with req_i |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i |
| irq_o | output | 1 | Level interrupt |

## Verification
The count is sampled on successive cycles at exponent 0 and across a 16-cycle tick at exponent 1. This separates a correct tick period from an off-by-one in the divider. The runs are repeated in one-shot mode, auto-reload mode and with the interrupt masked, which separates the raw flag, the interrupt level and the reload path. The three restart paths are exercised each with the timer on and off, so a restart that ignores enable, or a freeze that leaks a tick, shows up as a wrong count. Misaligned and out-of-range writes, and writes to unused control bits, are read back to show they have no effect.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned PRESC_W = 8;

  typedef enum logic [1:0] {
    SEL_LOAD  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_STAT  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [PRESC_W-1:0] presc;
    logic               irq_en;
    logic               reload;
    logic               en;
  } ctrl_t;

  // bit positions of control fields in the word
  localparam int unsigned CTL_EN_BIT     = 0;
  localparam int unsigned CTL_RELOAD_BIT = 1;
  localparam int unsigned CTL_IRQEN_BIT  = 2;
  localparam int unsigned CTL_PRESC_LSB  = 8;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned MAX_EXP = 3,
  parameter int unsigned EXP_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o
);
  localparam int unsigned DIV_W = 4 * MAX_EXP;

  logic [DIV_W-1:0]   div_q;
  logic [EXP_W-1:0]   exp_eff;
  logic [MAX_EXP-1:0] nib_done;

  assign exp_eff = (exp_i > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : exp_i;

  // each nibble of the divider contributes a factor of 16 when selected
  for (genvar g = 0; g < MAX_EXP; g++) begin : g_nib
    assign nib_done[g] = (exp_eff <= EXP_W'(g)) || (&div_q[4*g +: 4]);
  end

  assign tick_o = run_i && (&nib_done);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        div_q <= '0;
    else if (clr_i)     div_q <= '0;
    else if (tick_o)    div_q <= '0;
    else if (run_i)     div_q <= div_q + DIV_W'(1);
  end

  // R4
  single_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !clr_i && exp_i != '0) |=> (!tick_o || exp_i == '0));

  // R7
  frozen_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(div_q));
endmodule

// File: rtl/tmr_downcount.sv
module tmr_downcount #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] restart_val_i,
  input  logic             tick_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] reload_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             at_end;

  assign at_end = (cnt_q == '0) || (cnt_q == CNT_W'(1));
  assign zero_o = tick_i && armed_q && at_end && !restart_i;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q   <= restart_val_i;
      armed_q <= 1'b1;
    end else if (tick_i && armed_q) begin
      if (at_end) begin
        cnt_q   <= reload_i ? reload_val_i : '0;
        armed_q <= reload_i;
      end else begin
        cnt_q   <= cnt_q - CNT_W'(1);
      end
    end
  end

  // R9
  oneshot_park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !reload_i) |=> (cnt_o == '0));

  // R9
  reload_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && reload_i) |=> (cnt_o == $past(reload_val_i)));

  // R11
  hold_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !restart_i) |=> $stable(cnt_o));
endmodule

// File: rtl/tmr_regfile.sv
module tmr_regfile
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              zero_i,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] load_o,
  output logic              restart_o,
  output logic [DATA_W-1:0] restart_val_o,
  output logic              irq_o
);
  localparam int unsigned CTL_W = $bits(ctrl_t) + 5;

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] load_q;
  logic              raw_q, pend_q;
  logic              hit;
  reg_sel_e          sel;
  logic              wr_load, wr_count, wr_ctrl, wr_stat;
  logic              en_rise;
  logic [CTL_W-1:0]  ctrl_word;

  assign hit = (addr_i[1:0] == 2'b00) && (addr_i[ADDR_W-1:4] == '0);
  assign sel = reg_sel_e'(addr_i[3:2]);

  assign wr_load  = req_i && we_i && hit && (sel == SEL_LOAD);
  assign wr_count = req_i && we_i && hit && (sel == SEL_COUNT);
  assign wr_ctrl  = req_i && we_i && hit && (sel == SEL_CTRL);
  assign wr_stat  = req_i && we_i && hit && (sel == SEL_STAT);

  assign en_rise = wr_ctrl && !ctrl_q.en && wdata_i[CTL_EN_BIT];

  always_comb begin
    restart_o     = 1'b0;
    restart_val_o = wdata_i;
    if (wr_count) begin
      restart_o = 1'b1;
    end else if (wr_load && ctrl_q.en) begin
      restart_o = 1'b1;
    end else if (en_rise) begin
      restart_o     = 1'b1;
      restart_val_o = load_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      load_q <= '0;
    end else begin
      if (wr_load) load_q <= wdata_i;
      if (wr_ctrl) begin
        ctrl_q.en     <= wdata_i[CTL_EN_BIT];
        ctrl_q.reload <= wdata_i[CTL_RELOAD_BIT];
        ctrl_q.irq_en <= wdata_i[CTL_IRQEN_BIT];
        ctrl_q.presc  <= wdata_i[CTL_PRESC_LSB +: PRESC_W];
      end
    end
  end

  // zero event outranks a clearing write on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (zero_i) begin
      raw_q  <= 1'b1;
      pend_q <= pend_q || ctrl_q.irq_en;
    end else if (wr_stat) begin
      raw_q  <= 1'b0;
      pend_q <= 1'b0;
    end
  end

  assign ctrl_word = {ctrl_q.presc, 5'b0, ctrl_q.irq_en, ctrl_q.reload, ctrl_q.en};

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      unique case (sel)
        SEL_LOAD:  rdata_o = load_q;
        SEL_COUNT: rdata_o = cnt_i;
        SEL_CTRL:  rdata_o = DATA_W'(ctrl_word);
        SEL_STAT:  rdata_o = DATA_W'(raw_q);
        default:   rdata_o = '0;
      endcase
    end
  end

  assign ctrl_o = ctrl_q;
  assign load_o = load_q;
  assign irq_o  = pend_q;

  // R11
  zero_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_i |-> ctrl_q.en);

  // R8
  masked_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_i && !ctrl_q.irq_en && !pend_q) |=> !irq_o);

  // R8
  raw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_i |=> raw_q);

  // R10
  stat_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && !zero_i) |=> (!irq_o && !raw_q));

  // R12
  irq_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !wr_stat) |=> irq_o);

  // R8
  irq_has_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> raw_q);
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned MAX_EXP = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] load_val, restart_val, cnt;
  logic              restart, tick, zero;

  tmr_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .cnt_i(cnt), .zero_i(zero), .ctrl_o(ctrl), .load_o(load_val),
    .restart_o(restart), .restart_val_o(restart_val), .irq_o
  );

  tmr_prescaler #(.MAX_EXP(MAX_EXP), .EXP_W(PRESC_W)) u_presc (
    .clk_i, .rst_ni, .run_i(ctrl.en), .clr_i(restart),
    .exp_i(ctrl.presc), .tick_o(tick)
  );

  tmr_downcount #(.CNT_W(DATA_W)) u_cnt (
    .clk_i, .rst_ni, .restart_i(restart), .restart_val_i(restart_val),
    .tick_i(tick), .reload_i(ctrl.reload), .reload_val_i(load_val),
    .cnt_o(cnt), .zero_o(zero)
  );
endmodule

// File: tb/prescaled_timer_bench.sv
`timescale 1ns/1ps
module prescaled_timer_bench;
  localparam int DW = 32;
  localparam int AW = 6;
  localparam logic [AW-1:0] A_LOAD = 6'h00, A_CNT = 6'h04, A_CTL = 6'h08, A_STAT = 6'h0C;

  typedef struct {
    logic [DW-1:0] exp_data;
    logic          exp_irq;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;
  int            n_run = 0, n_fail = 0;
  bit            done = 1'b0;
  item_t         sb_q[$];

  always #4 clk = ~clk;

  prescaled_timer u_prescaled_timer (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // monitor
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_run++;
      if (rdata !== it.exp_data || irq !== it.exp_irq) begin
        n_fail++;
        $display("FAIL %s: data=%h irq=%b expected data=%h irq=%b",
                 it.tag, rdata, irq, it.exp_data, it.exp_irq);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(posedge clk); #1;
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic chk(input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic i, input string tag);
    item_t it;
    @(posedge clk); #1;
    addr = a;
    it.exp_data = d; it.exp_irq = i; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: data=%h irq=%b expected data=%h irq=%b", rdata, irq, 0, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3); #1 rst_n = 1'b1;
    // R1 reset state
    chk(A_LOAD, 0, 0, "R1 load");
    chk(A_CNT,  0, 0, "R1 count");
    chk(A_CTL,  0, 0, "R1 ctrl");
    chk(A_STAT, 0, 0, "R1 status");

    // R5 load while disabled
    wr(A_LOAD, 5);
    chk(A_LOAD, 5, 0, "R5 load stored");
    chk(A_CNT,  0, 0, "R5 count untouched");

    // R7 R4 R8 one-shot with irq, exponent 0
    wr(A_CTL, 32'h5);
    chk(A_CNT, 4, 0, "R4 j=1");
    chk(A_CNT, 3, 0, "R4 j=2");
    chk(A_CNT, 2, 0, "R4 j=3");
    chk(A_CNT, 1, 0, "R4 j=4");
    chk(A_CNT, 0, 1, "R8 zero irq");
    idle(8);
    chk(A_STAT, 1, 1, "R12 irq held");
    // R10 clear
    wr(A_STAT, 32'hDEAD);
    chk(A_STAT, 0, 0, "R10 cleared");
    idle(10);
    chk(A_CNT, 0, 0, "R9 parked");
    chk(A_STAT, 0, 0, "R9 no refire");

    // R9 auto-reload
    wr(A_CTL, 0);
    wr(A_LOAD, 3);
    wr(A_CTL, 32'h7);
    chk(A_CNT, 2, 0, "R9 ar j=1");
    chk(A_CNT, 1, 0, "R9 ar j=2");
    chk(A_CNT, 3, 1, "R9 reloaded");
    chk(A_STAT, 1, 1, "R8 raw set");

    // R8 masked interrupt
    wr(A_CTL, 0);
    wr(A_STAT, 0);
    wr(A_LOAD, 2);
    wr(A_CTL, 32'h1);
    chk(A_STAT, 0, 0, "R8 masked j=1");
    chk(A_STAT, 1, 0, "R8 masked raw only");

    // R4 exponent 1: tick every 16 cycles
    wr(A_CTL, 0);
    wr(A_STAT, 0);
    wr(A_LOAD, 2);
    wr(A_CTL, 32'h101);
    idle(14);
    chk(A_CNT, 2, 0, "R4 before 16");
    chk(A_CNT, 1, 0, "R4 at 16");
    idle(15);
    chk(A_CNT, 0, 0, "R4 at 32");

    // R5 load while enabled restarts
    wr(A_CTL, 32'h1);
    wr(A_LOAD, 7);
    chk(A_CNT, 6, 0, "R5 restart");
    // R6 count write while enabled
    wr(A_CNT, 20);
    chk(A_CNT, 19, 0, "R6 enabled");
    // R7 disable freezes (tick on the disabling edge still lands)
    wr(A_CTL, 0);
    chk(A_CNT, 17, 0, "R7 frozen");
    idle(5);
    chk(A_CNT, 17, 0, "R7 still frozen");
    // R6 count write while disabled
    wr(A_CNT, 9);
    chk(A_CNT, 9, 0, "R6 disabled write");
    idle(4);
    chk(A_CNT, 9, 0, "R6 no count");
    // R11 no zero event while disabled
    wr(A_STAT, 0);
    wr(A_CNT, 1);
    idle(6);
    chk(A_STAT, 0, 0, "R11 no event");
    chk(A_CNT, 1, 0, "R11 count held");
    // R7 enable rise restarts from load
    wr(A_CTL, 32'h1);
    chk(A_CNT, 6, 0, "R7 rise from load");

    // R2 decode
    wr(A_CTL, 0);
    wr(6'h01, 32'h55);
    chk(A_LOAD, 7, 0, "R2 misaligned ignored");
    wr(6'h10, 32'h55);
    chk(6'h10, 0, 0, "R2 out of range");
    chk(A_LOAD, 7, 0, "R2 load intact");

    // R3 control layout
    wr(A_CTL, 32'hFFFF_FFF8);
    chk(A_CTL, 32'h0000_FF00, 0, "R3 unused bits");
    wr(A_CTL, 32'h0000_0306);
    chk(A_CTL, 32'h0000_0306, 0, "R3 fields");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule